// File: doc/BRIEF.md
# Read Latency and Valid-Strobe Calibrator

This block measures, during memory interface calibration, how many controller clock cycles pass between a calibration read command and the first cycle in which the returned data is reported as correct. A calibration is armed by a request pulse. The block then waits for the read command, counts cycles, and stops when the data-match input first goes high. If no match arrives within the longest supported latency, the attempt is flagged as failed. A successful count is published as the read latency and held until a later calibration replaces it.

The block also keeps the write latency figure that the calibration sequencer hands over while a calibration is running.

Once calibration has succeeded, the block turns each user read command into a one-cycle read-data-valid strobe, delayed by the measured latency. The controller can use this strobe instead of counting cycles itself. Every read in flight travels down its own slot of a delay line, so reads issued on consecutive cycles each produce their own strobe.

Top module: `rlat_cal_top`

## Requirements
- R1: After reset, `rlat_o`, `wlat_o`, `cal_done_o`, `cal_fail_o`, `busy_o` and `rd_valid_o` are all zero.
- R2: A `cal_req_i` pulse seen while idle raises `busy_o` and clears `cal_done_o` and `cal_fail_o` after that edge. A `cal_req_i` seen while busy is ignored and does not restart the measurement.
- R3: If `cal_rd_i` is sampled at edge t and `cal_match_i` is first sampled high at edge t+L (1 <= L <= MAX_LAT), then after edge t+L `rlat_o` equals L, `cal_done_o` is 1 and `busy_o` is 0. A match sampled before the read command, and any further read command during counting, are ignored.
- R4: If no match is sampled up to and including edge t+MAX_LAT, then `cal_fail_o` goes to 1, `cal_done_o` stays 0 and `busy_o` returns to 0.
- R5: `rlat_o` keeps its value while a calibration runs and after a failed calibration. It changes only when a calibration succeeds.
- R6: `wlat_o` takes `wlat_in_i` on an edge where `wlat_load_i` is high while `busy_o` is 1. A load while idle has no effect.
- R7: With `cal_done_o` at 1 and `rlat_o` = L, a `user_rd_i` sampled high at edge e makes `rd_valid_o` high for exactly the one cycle that ends at edge e+L.
- R8: User reads on consecutive cycles each produce their own strobe, on consecutive cycles.
- R9: User reads sampled while `cal_done_o` is 0 (before any calibration, during one, or after a failure) produce no strobe. Strobes still in flight are discarded when a calibration starts.
- R10: The longest latency, L = MAX_LAT (31 by default), is accepted as a success, and its strobe appears L cycles after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_req_i | input | 1 | Calibration request pulse |
| cal_rd_i | input | 1 | Calibration read command issued |
| cal_match_i | input | 1 | Returned data equals the expected pattern |
| wlat_load_i | input | 1 | Write latency load strobe from the sequencer |
| wlat_in_i | input | WLAT_W | Write latency value from the sequencer |
| user_rd_i | input | 1 | User-mode read command |
| rlat_o | output | LAT_W | Calibrated read latency in cycles |
| wlat_o | output | WLAT_W | Held write latency |
| cal_done_o | output | 1 | Last calibration succeeded |
| cal_fail_o | output | 1 | Last calibration timed out |
| busy_o | output | 1 | Calibration in progress |
| rd_valid_o | output | 1 | Calibrated read-data-valid strobe |

## Verification
The hardest case to reach is a strobe that is still in flight when a new calibration begins. It can only be seen if the old latency remains selected for long enough. The stimulus therefore issues a user read at the largest latency and, a few cycles later, starts a calibration that is made to time out. The old latency is kept through the whole 31-cycle window, so a strobe that was not flushed would surface while the scoreboard expects none. A second delicate case is a duplicate request and a duplicate read command arriving in the middle of counting. The stimulus places both there and checks that the latency reported afterwards still counts from the first command.

// File: rtl/rlc_pkg.sv
`timescale 1ns/1ps
package rlc_pkg;
  typedef enum logic [1:0] {
    CAL_IDLE  = 2'd0,
    CAL_ARMED = 2'd1,
    CAL_COUNT = 2'd2
  } cal_state_e;
endpackage

// File: rtl/rlc_measure.sv
`timescale 1ns/1ps
module rlc_measure #(
  parameter int MAX_LAT = 31,
  parameter int LAT_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             issue_i,
  input  logic             match_i,
  output logic [LAT_W-1:0] rlat_o,
  output logic             done_o,
  output logic             fail_o,
  output logic             busy_o
);
  import rlc_pkg::*;

  localparam logic [LAT_W-1:0] LIMIT = LAT_W'(MAX_LAT);
  localparam logic [LAT_W-1:0] ONE   = LAT_W'(1);

  cal_state_e       st_q, st_d;
  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic [LAT_W-1:0] rlat_q;
  logic             done_q, done_d;
  logic             fail_q, fail_d;
  logic             cnt_en, rlat_en, flag_en;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    done_d  = done_q;
    fail_d  = fail_q;
    cnt_en  = 1'b0;
    rlat_en = 1'b0;
    flag_en = 1'b0;
    unique case (st_q)
      CAL_IDLE: begin
        if (start_i) begin
          st_d    = CAL_ARMED;
          done_d  = 1'b0;
          fail_d  = 1'b0;
          flag_en = 1'b1;
        end
      end
      CAL_ARMED: begin
        if (issue_i) begin
          st_d   = CAL_COUNT;
          cnt_d  = ONE;
          cnt_en = 1'b1;
        end
      end
      CAL_COUNT: begin
        if (match_i) begin
          st_d    = CAL_IDLE;
          rlat_en = 1'b1;
          done_d  = 1'b1;
          flag_en = 1'b1;
        end else if (cnt_q == LIMIT) begin
          st_d    = CAL_IDLE;
          fail_d  = 1'b1;
          flag_en = 1'b1;
        end else begin
          cnt_d  = cnt_q + ONE;
          cnt_en = 1'b1;
        end
      end
      default: st_d = CAL_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CAL_IDLE;
      cnt_q  <= '0;
      rlat_q <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (rlat_en) rlat_q <= cnt_q;
      if (flag_en) begin
        done_q <= done_d;
        fail_q <= fail_d;
      end
    end
  end

  assign rlat_o = rlat_q;
  assign done_o = done_q;
  assign fail_o = fail_q;
  assign busy_o = (st_q != CAL_IDLE);

  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CAL_IDLE && start_i) |=> (busy_o && !done_o && !fail_o));
  a_r3_rlat_range: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (rlat_q != '0 && rlat_q <= LIMIT));
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CAL_COUNT) |-> (cnt_q >= ONE && cnt_q <= LIMIT));
  a_r4_done_fail_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && fail_q));
  a_r5_rlat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != CAL_COUNT) |=> $stable(rlat_q));
endmodule

// File: rtl/rlc_valid_gen.sv
`timescale 1ns/1ps
module rlc_valid_gen #(
  parameter int MAX_LAT = 31,
  parameter int LAT_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             rd_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             valid_o
);
  logic [MAX_LAT-1:0] sr_q, sr_d;

  // each stage moves a read one cycle further; a disabled stage clears
  for (genvar g = 0; g < MAX_LAT; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign sr_d[g] = en_i & rd_i;
    end else begin : g_body
      assign sr_d[g] = en_i & sr_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  // tap selection by calibrated latency
  always_comb begin
    valid_o = 1'b0;
    for (int k = 0; k < MAX_LAT; k++) begin
      if (lat_i == LAT_W'(k + 1)) valid_o = sr_q[k];
    end
  end

  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (sr_q == '0));
  a_r7_tap_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (lat_i != '0));
endmodule

// File: rtl/rlc_wlat_hold.sv
`timescale 1ns/1ps
module rlc_wlat_hold #(
  parameter int WLAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              load_i,
  input  logic [WLAT_W-1:0] wlat_i,
  output logic [WLAT_W-1:0] wlat_o
);
  logic              load_en;
  logic [WLAT_W-1:0] wlat_q;

  always_comb load_en = accept_i & load_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wlat_q <= '0;
    else if (load_en) wlat_q <= wlat_i;
  end

  assign wlat_o = wlat_q;

  a_r6_wlat_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_i && load_i) |=> $stable(wlat_o));
  a_r6_wlat_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && load_i) |=> (wlat_o == $past(wlat_i)));
endmodule

// File: rtl/rlat_cal_top.sv
`timescale 1ns/1ps
module rlat_cal_top #(
  parameter  int MAX_LAT = 31,
  parameter  int WLAT_W  = 4,
  localparam int LAT_W   = $clog2(MAX_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_req_i,
  input  logic              cal_rd_i,
  input  logic              cal_match_i,
  input  logic              wlat_load_i,
  input  logic [WLAT_W-1:0] wlat_in_i,
  input  logic              user_rd_i,
  output logic [LAT_W-1:0]  rlat_o,
  output logic [WLAT_W-1:0] wlat_o,
  output logic              cal_done_o,
  output logic              cal_fail_o,
  output logic              busy_o,
  output logic              rd_valid_o
);
  logic [LAT_W-1:0] rlat_w;
  logic             done_w, busy_w;

  rlc_measure #(.MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u_measure (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (cal_req_i),
    .issue_i (cal_rd_i),
    .match_i (cal_match_i),
    .rlat_o  (rlat_w),
    .done_o  (done_w),
    .fail_o  (cal_fail_o),
    .busy_o  (busy_w)
  );

  rlc_valid_gen #(.MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u_valid (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (done_w),
    .rd_i    (user_rd_i),
    .lat_i   (rlat_w),
    .valid_o (rd_valid_o)
  );

  rlc_wlat_hold #(.WLAT_W(WLAT_W)) u_wlat (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (busy_w),
    .load_i   (wlat_load_i),
    .wlat_i   (wlat_in_i),
    .wlat_o   (wlat_o)
  );

  assign rlat_o     = rlat_w;
  assign cal_done_o = done_w;
  assign busy_o     = busy_w;

  a_r9_valid_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(done_w));
endmodule

// File: tb/rlat_cal_top_tb_top.sv
`timescale 1ns/1ps
module rlat_cal_top_tb_top;
  localparam int MAX_LAT = 31;
  localparam int WLAT_W  = 4;
  localparam int LAT_W   = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cal_req, cal_rd, cal_match, wlat_load, user_rd;
  logic [WLAT_W-1:0] wlat_in;
  logic [LAT_W-1:0]  rlat;
  logic [WLAT_W-1:0] wlat;
  logic              done, fail, busy, rd_valid;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  int expq[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rlat_cal_top #(.MAX_LAT(MAX_LAT), .WLAT_W(WLAT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cal_req_i(cal_req), .cal_rd_i(cal_rd),
    .cal_match_i(cal_match), .wlat_load_i(wlat_load), .wlat_in_i(wlat_in),
    .user_rd_i(user_rd), .rlat_o(rlat), .wlat_o(wlat), .cal_done_o(done),
    .cal_fail_o(fail), .busy_o(busy), .rd_valid_o(rd_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: pops expected strobe edges, flags any strobe not expected
  always @(negedge clk) begin
    if (mon_on) begin
      if (expq.size() > 0 && expq[0] == cyc + 1) begin
        void'(expq.pop_front());
        chk(rd_valid == 1'b1, "R7/R8 strobe at expected cycle", int'(rd_valid), 1);
      end else if (rd_valid) begin
        chk(1'b0, "R9 unexpected strobe", 1, 0);
      end
    end
  end

  // driver: n consecutive user reads, expected strobes pushed when exp set
  task automatic rd_burst(input int n, input int lat, input bit exp);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      user_rd = 1'b1;
      if (exp) expq.push_back(cyc + 1 + lat);
    end
    @(negedge clk);
    user_rd = 1'b0;
  endtask

  task automatic drain();
    repeat (MAX_LAT + 3) @(negedge clk);
  endtask

  // lat == 0: no match is ever returned
  task automatic run_cal(input int lat, input bit ldw, input int wv);
    @(negedge clk); cal_req = 1'b1;
    @(negedge clk); cal_req = 1'b0;
    chk(busy == 1'b1, "R2 busy after request", int'(busy), 1);
    chk(done == 1'b0 && fail == 1'b0, "R2 flags cleared", int'({done, fail}), 0);
    cal_rd = 1'b1;
    if (ldw) begin wlat_load = 1'b1; wlat_in = WLAT_W'(wv); end
    @(negedge clk); cal_rd = 1'b0; wlat_load = 1'b0;
    if (lat > 0) begin
      repeat (lat - 1) @(negedge clk);
      cal_match = 1'b1;
      @(negedge clk); cal_match = 1'b0;
    end else begin
      repeat (MAX_LAT) @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    rst_n = 1'b0; cal_req = 0; cal_rd = 0; cal_match = 0;
    wlat_load = 0; wlat_in = '0; user_rd = 0;
    repeat (3) @(negedge clk);
    chk(rlat == 0 && wlat == 0, "R1 latencies reset", int'(rlat) + int'(wlat), 0);
    chk({done, fail, busy, rd_valid} == 4'b0, "R1 flags reset", int'({done, fail, busy, rd_valid}), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R9: reads before any calibration are dropped
    rd_burst(2, 0, 0);
    drain();

    // R3 and R6: latency 5, write latency loaded while busy
    run_cal(5, 1, 6);
    chk(rlat == 5, "R3 measured latency 5", int'(rlat), 5);
    chk(done == 1'b1 && busy == 1'b0, "R3 done and idle", int'({done, busy}), 2);
    chk(wlat == 6, "R6 write latency loaded", int'(wlat), 6);
    @(negedge clk); wlat_load = 1'b1; wlat_in = 4'd9;
    @(negedge clk); wlat_load = 1'b0;
    @(negedge clk);
    chk(wlat == 6, "R6 idle load ignored", int'(wlat), 6);

    // R7 single read, R8 back-to-back
    rd_burst(1, 5, 1);
    rd_burst(3, 5, 1);
    drain();

    // R2/R3: duplicate request and read during counting ignored, latency 4
    @(negedge clk); cal_req = 1'b1;
    @(negedge clk); cal_req = 1'b0; cal_rd = 1'b1;
    @(negedge clk); cal_rd = 1'b0; cal_req = 1'b1;
    @(negedge clk); cal_req = 1'b0; cal_rd = 1'b1;
    @(negedge clk); cal_rd = 1'b0;
    @(negedge clk); cal_match = 1'b1;
    @(negedge clk); cal_match = 1'b0;
    chk(rlat == 4, "R2 busy request ignored, R3 latency 4", int'(rlat), 4);
    chk(done == 1'b1, "R3 done after latency 4", int'(done), 1);

    // R3: match before read command ignored, latency 2
    @(negedge clk); cal_req = 1'b1;
    @(negedge clk); cal_req = 1'b0; cal_match = 1'b1;
    @(negedge clk); cal_match = 1'b0; cal_rd = 1'b1;
    @(negedge clk); cal_rd = 1'b0;
    @(negedge clk); cal_match = 1'b1;
    @(negedge clk); cal_match = 1'b0;
    chk(rlat == 2, "R3 early match ignored, latency 2", int'(rlat), 2);
    rd_burst(2, 2, 1);
    drain();

    // R4/R5: timeout keeps old latency, R9 reads after failure dropped
    run_cal(0, 0, 0);
    chk(fail == 1'b1 && done == 1'b0, "R4 failure flagged", int'({done, fail}), 1);
    chk(busy == 1'b0, "R4 idle after timeout", int'(busy), 0);
    chk(rlat == 2, "R5 latency held on failure", int'(rlat), 2);
    rd_burst(2, 0, 0);
    drain();

    // R10: maximum latency
    run_cal(MAX_LAT, 0, 0);
    chk(rlat == MAX_LAT, "R10 maximum latency accepted", int'(rlat), MAX_LAT);
    chk(done == 1'b1, "R10 done at maximum", int'(done), 1);
    rd_burst(2, MAX_LAT, 1);
    drain();

    // R9: in-flight strobe discarded when calibration starts (and fails)
    rd_burst(1, MAX_LAT, 0);
    repeat (2) @(negedge clk);
    run_cal(0, 0, 0);
    chk(rlat == MAX_LAT, "R5 latency held during failed run", int'(rlat), MAX_LAT);
    drain();

    // R7/R8 at latency 3 and latency 1
    run_cal(3, 0, 0);
    chk(rlat == 3, "R3 latency 3", int'(rlat), 3);
    rd_burst(2, 3, 1);
    drain();
    run_cal(1, 0, 0);
    chk(rlat == 1, "R3 latency 1", int'(rlat), 1);
    rd_burst(3, 1, 1);
    drain();

    chk(expq.size() == 0, "R7 all expected strobes seen", expq.size(), 0);
    summary();
  end
endmodule